// File: doc/BRIEF.md
# Flash Write-Enable and Completion Sequencer

This block sits between a requester and an SPI command engine and turns a protected flash write into a single hardware operation. A caller presents an optional prefix opcode (normally write enable), a main opcode with its transmit and receive byte counts, and a flag that asks for completion polling. It then pulses `start`. The sequencer issues the prefix as a transaction of its own. It polls the flash status register until the write-enable latch is set. It launches the main command. When asked, it polls status again until the write-in-progress bit clears.

Every transaction goes to the engine through a launch/busy handshake. The engine owns the data buffer, so the sequencer only passes the opcode and the counts. Each polling phase is limited to a parameterised number of status reads. The outcome is reported as `seq_done` or `seq_error`, and it stays visible until the next accepted start.

Top module: `fprog_seq`

## Requirements
- R1: While `rst` is high and after it is released, `seq_busy`, `seq_done`, `seq_error` and `eng_launch` are all low until a start is accepted.
- R2: A nonzero prefix opcode is launched first, as its own transaction with transmit count 0 and receive count 0.
- R3: A prefix opcode of 0x00 skips the prefix and the write-enable poll, so the first transaction launched is the main command.
- R4: Every status read is one transaction with opcode 0x05, transmit count 0 and receive count 1; the status byte is the engine's read data after busy drops.
- R5: After the prefix, status reads repeat until status bit 1 (write-enable latch) reads 1, and only then is the main command launched.
- R6: The main command is launched with the opcode and the transmit and receive counts captured when start was accepted, and input changes after that have no effect.
- R7: With the completion flag set, status reads follow the main command until status bit 0 (write in progress) reads 0, and then `seq_done` is raised.
- R8: With the completion flag clear, `seq_done` is raised as soon as the main command's transaction ends, and no status read follows it.
- R9: A polling phase makes at most MAX_POLLS status reads (default 1024). If the last one still fails the test, `seq_error` is raised and nothing more is launched. A pass on exactly the MAX_POLLS-th read still succeeds.
- R10: `start` is accepted only while no sequence is running. A start during a sequence is ignored and launches nothing extra.
- R11: `seq_done` and `seq_error` are never high together. Each holds until the next accepted start, which clears it in the cycle it is accepted.
- R12: `eng_launch` is a one-cycle pulse, raised only while `eng_busy` is low, and exactly one launch is made per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled when not busy |
| pre_op | input | 8 | Prefix opcode, 0x00 for none |
| main_op | input | 8 | Main command opcode |
| main_tx_cnt | input | 8 | Main command transmit byte count |
| main_rx_cnt | input | 8 | Main command receive byte count |
| wait_done | input | 1 | Request completion polling after the main command |
| seq_busy | output | 1 | A sequence is running |
| seq_done | output | 1 | Last sequence finished successfully |
| seq_error | output | 1 | Last sequence ran out of status reads |
| eng_launch | output | 1 | One-cycle launch pulse to the engine |
| eng_opcode | output | 8 | Opcode of the current transaction |
| eng_tx_cnt | output | 8 | Transmit count of the current transaction |
| eng_rx_cnt | output | 8 | Receive count of the current transaction |
| eng_busy | input | 1 | Engine is executing a transaction |
| eng_rdata | input | 8 | First received byte of the last transaction |

## Verification
On every cycle the assertions check the single-cycle launch pulse and its exclusion against engine busy, the silence of the launch line outside a sequence, and the mutual exclusion and holding of done and error. They also check the quiet state after reset and a counter-based bound on status reads in each polling phase. The order of transactions, the exact opcodes and counts, and the choice between skipping and running each phase can only be shown by the bench's scenarios. The same holds for the boundary between success on the last allowed read and failure one read later, and for an ignored mid-sequence start. In those scenarios a flash model answers each status read with a programmed number of failures.

// File: rtl/fprog_pkg.sv
package fprog_pkg;

    parameter int OPC_W  = 8;
    parameter int CNT_W  = 8;
    parameter int STAT_W = 8;

    localparam logic [OPC_W-1:0] RDSR_OP = OPC_W'(8'h05);
    localparam int               WEL_POS = 1;
    localparam int               WIP_POS = 0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_WEL,
        PH_MAIN,
        PH_WIP,
        PH_DONE,
        PH_FAIL
    } phase_e;

    typedef enum logic [1:0] {
        ST_ISSUE,
        ST_SETTLE,
        ST_WAIT
    } step_e;

    typedef struct packed {
        logic [OPC_W-1:0] pre_op;
        logic [OPC_W-1:0] main_op;
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] rx;
        logic             wait_done;
    } req_t;

    typedef struct packed {
        logic [OPC_W-1:0] op;
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] rx;
    } cmd_t;

    function automatic logic is_resting(phase_e p);
        return (p == PH_IDLE) || (p == PH_DONE) || (p == PH_FAIL);
    endfunction

    function automatic logic poll_met(phase_e p, logic [STAT_W-1:0] s);
        if (p == PH_WEL) return s[WEL_POS];
        return !s[WIP_POS];
    endfunction

endpackage

// File: rtl/fprog_retry.sv
module fprog_retry #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int CW = $clog2(MAX_POLLS) + 1;
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign exhausted = (cnt == LAST);
endmodule

// File: rtl/fprog_cmd_mux.sv
module fprog_cmd_mux
    import fprog_pkg::*;
(
    input  phase_e phase,
    input  req_t   req,
    output cmd_t   cmd
);
    always_comb begin
        cmd = '0;
        unique case (phase)
            PH_PRE: begin
                cmd.op = req.pre_op;
                cmd.tx = '0;
                cmd.rx = '0;
            end
            PH_WEL, PH_WIP: begin
                cmd.op = RDSR_OP;
                cmd.tx = '0;
                cmd.rx = CNT_W'(1);
            end
            PH_MAIN: begin
                cmd.op = req.main_op;
                cmd.tx = req.tx;
                cmd.rx = req.rx;
            end
            default: cmd = '0;
        endcase
    end
endmodule

// File: rtl/fprog_ctrl.sv
module fprog_ctrl
    import fprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  req_t              req_in,
    input  logic              eng_busy,
    input  logic [STAT_W-1:0] eng_rdata,
    input  logic              exhausted,
    output phase_e            phase,
    output req_t              req_q,
    output logic              launch,
    output logic              retry_clr,
    output logic              retry_inc
);
    step_e  step, step_n;
    phase_e phase_n;
    logic   accept;

    always_comb begin
        phase_n   = phase;
        step_n    = step;
        accept    = 1'b0;
        retry_clr = 1'b0;
        retry_inc = 1'b0;
        if (is_resting(phase)) begin
            if (start) begin
                accept    = 1'b1;
                retry_clr = 1'b1;
                phase_n   = (req_in.pre_op != '0) ? PH_PRE : PH_MAIN;
                step_n    = ST_ISSUE;
            end
        end else begin
            unique case (step)
                ST_ISSUE:  step_n = ST_SETTLE;
                ST_SETTLE: step_n = ST_WAIT;
                default: begin
                    if (!eng_busy) begin
                        step_n = ST_ISSUE;
                        unique case (phase)
                            PH_PRE: begin
                                phase_n   = PH_WEL;
                                retry_clr = 1'b1;
                            end
                            PH_WEL, PH_WIP: begin
                                if (poll_met(phase, eng_rdata)) begin
                                    phase_n = (phase == PH_WEL) ? PH_MAIN : PH_DONE;
                                end else if (exhausted) begin
                                    phase_n = PH_FAIL;
                                end else begin
                                    retry_inc = 1'b1;
                                end
                            end
                            PH_MAIN: begin
                                if (req_q.wait_done) begin
                                    phase_n   = PH_WIP;
                                    retry_clr = 1'b1;
                                end else begin
                                    phase_n = PH_DONE;
                                end
                            end
                            default: phase_n = phase;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= ST_ISSUE;
            req_q <= '0;
        end else begin
            phase <= phase_n;
            step  <= step_n;
            if (accept) req_q <= req_in;
        end
    end

    assign launch = !is_resting(phase) && (step == ST_ISSUE);
endmodule

// File: rtl/fprog_seq.sv
module fprog_seq
    import fprog_pkg::*;
#(
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPC_W-1:0]  pre_op,
    input  logic [OPC_W-1:0]  main_op,
    input  logic [CNT_W-1:0]  main_tx_cnt,
    input  logic [CNT_W-1:0]  main_rx_cnt,
    input  logic              wait_done,
    output logic              seq_busy,
    output logic              seq_done,
    output logic              seq_error,
    output logic              eng_launch,
    output logic [OPC_W-1:0]  eng_opcode,
    output logic [CNT_W-1:0]  eng_tx_cnt,
    output logic [CNT_W-1:0]  eng_rx_cnt,
    input  logic              eng_busy,
    input  logic [STAT_W-1:0] eng_rdata
);
    req_t   req_in, req_q;
    cmd_t   cmd;
    phase_e cur_phase;
    logic   retry_clr, retry_inc, exhausted;

    assign req_in = '{pre_op: pre_op, main_op: main_op, tx: main_tx_cnt,
                      rx: main_rx_cnt, wait_done: wait_done};

    fprog_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_in    (req_in),
        .eng_busy  (eng_busy),
        .eng_rdata (eng_rdata),
        .exhausted (exhausted),
        .phase     (cur_phase),
        .req_q     (req_q),
        .launch    (eng_launch),
        .retry_clr (retry_clr),
        .retry_inc (retry_inc)
    );

    fprog_retry #(.MAX_POLLS(MAX_POLLS)) u_retry (
        .clk       (clk),
        .rst       (rst),
        .clr       (retry_clr),
        .inc       (retry_inc),
        .exhausted (exhausted)
    );

    fprog_cmd_mux u_mux (
        .phase (cur_phase),
        .req   (req_q),
        .cmd   (cmd)
    );

    assign eng_opcode = cmd.op;
    assign eng_tx_cnt = cmd.tx;
    assign eng_rx_cnt = cmd.rx;
    assign seq_busy   = !is_resting(cur_phase);
    assign seq_done   = (cur_phase == PH_DONE);
    assign seq_error  = (cur_phase == PH_FAIL);
endmodule

// File: rtl/fprog_seq_chk.sv
module fprog_seq_chk
    import fprog_pkg::*;
#(
    parameter int MAX_POLLS = 1024
) (
    input logic   clk,
    input logic   rst,
    input logic   start,
    input logic   seq_busy,
    input logic   seq_done,
    input logic   seq_error,
    input logic   eng_launch,
    input logic   eng_busy,
    input phase_e cur_phase
);
    int unsigned polls;

    always_ff @(posedge clk) begin
        if (rst) begin
            polls <= 0;
        end else if (!(cur_phase == PH_WEL || cur_phase == PH_WIP)) begin
            polls <= 0;
        end else if (eng_launch) begin
            polls <= polls + 1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!seq_busy && !seq_done && !seq_error && !eng_launch));

    p_poll_bound_r9: assert property (@(posedge clk) disable iff (rst)
        polls <= MAX_POLLS);

    p_fail_silent_r9: assert property (@(posedge clk) disable iff (rst)
        seq_error |-> !eng_launch);

    p_idle_silent_r10: assert property (@(posedge clk) disable iff (rst)
        !seq_busy |-> !eng_launch);

    p_excl_result_r11: assert property (@(posedge clk) disable iff (rst)
        !(seq_done && seq_error));

    p_hold_done_r11: assert property (@(posedge clk) disable iff (rst)
        (seq_done && !start) |=> seq_done);

    p_hold_error_r11: assert property (@(posedge clk) disable iff (rst)
        (seq_error && !start) |=> seq_error);

    p_launch_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        eng_launch |=> !eng_launch);

    p_launch_free_r12: assert property (@(posedge clk) disable iff (rst)
        eng_launch |-> !eng_busy);
endmodule

bind fprog_seq fprog_seq_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .seq_busy   (seq_busy),
    .seq_done   (seq_done),
    .seq_error  (seq_error),
    .eng_launch (eng_launch),
    .eng_busy   (eng_busy),
    .cur_phase  (cur_phase)
);

// File: tb/test_fprog_seq.sv
module test_fprog_seq;
    localparam int MAXP = 1024;
    localparam int LAT  = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] pre_op = '0, main_op = '0, main_tx_cnt = '0, main_rx_cnt = '0;
    logic       wait_done = 1'b0;
    logic       seq_busy, seq_done, seq_error, eng_launch;
    logic [7:0] eng_opcode, eng_tx_cnt, eng_rx_cnt;
    logic       eng_busy = 1'b0;
    logic [7:0] eng_rdata = '0;

    always #5 clk = ~clk;

    fprog_seq #(.MAX_POLLS(MAXP)) i_fprog_seq (
        .clk(clk), .rst(rst), .start(start), .pre_op(pre_op), .main_op(main_op),
        .main_tx_cnt(main_tx_cnt), .main_rx_cnt(main_rx_cnt), .wait_done(wait_done),
        .seq_busy(seq_busy), .seq_done(seq_done), .seq_error(seq_error),
        .eng_launch(eng_launch), .eng_opcode(eng_opcode), .eng_tx_cnt(eng_tx_cnt),
        .eng_rx_cnt(eng_rx_cnt), .eng_busy(eng_busy), .eng_rdata(eng_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [23:0] exp_q[$];

    // flash + engine model
    int   wel_lag, wip_lag, rd_cnt, nonstat_idx, left;
    bit   has_pre, in_wel;
    logic [7:0] pend;

    always @(posedge clk) begin
        if (rst) begin
            eng_busy  <= 1'b0;
            eng_rdata <= '0;
            left = 0;
        end else if (eng_launch && !eng_busy) begin
            eng_busy  <= 1'b1;
            eng_rdata <= 8'hA5;
            left = LAT;
            if (eng_opcode == 8'h05) begin
                rd_cnt++;
                if (in_wel) pend = {6'b0, 1'(rd_cnt > wel_lag), 1'b1};
                else        pend = {6'b0, 1'b1, 1'(rd_cnt <= wip_lag)};
            end else begin
                in_wel = has_pre && (nonstat_idx == 0);
                nonstat_idx++;
                rd_cnt = 0;
                pend = 8'h00;
            end
        end else if (eng_busy) begin
            left--;
            if (left == 0) begin
                eng_busy  <= 1'b0;
                eng_rdata <= pend;
            end
        end
    end

    // monitor: pops expected transactions as the design launches them
    always @(negedge clk) begin
        if (!rst && eng_launch) begin
            checks++;
            if (eng_busy) begin
                fails++;
                $display("FAIL R12 launch while engine busy: busy=%b exp=0", eng_busy);
            end
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10/R12 unexpected launch: got op=%h tx=%0d rx=%0d exp none",
                         eng_opcode, eng_tx_cnt, eng_rx_cnt);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                if ({eng_opcode, eng_tx_cnt, eng_rx_cnt} != e) begin
                    fails++;
                    $display("FAIL R2/R4/R5/R6 transaction: got op=%h tx=%0d rx=%0d exp op=%h tx=%0d rx=%0d",
                             eng_opcode, eng_tx_cnt, eng_rx_cnt, e[23:16], e[15:8], e[7:0]);
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", what, got, exp);
        end
    endtask

    task automatic push_polls(input int lag, output bit err);
        int n;
        n = (lag + 1 > MAXP) ? MAXP : lag + 1;
        for (int i = 0; i < n; i++) exp_q.push_back({8'h05, 8'd0, 8'd1});
        err = (lag + 1 > MAXP);
    endtask

    task automatic run_seq(input logic [7:0] pre, input logic [7:0] mop,
                           input logic [7:0] tx, input logic [7:0] rx, input bit wd,
                           input int l_wel, input int l_wip, input bit inject,
                           input string tag);
        bit err;
        err = 1'b0;
        if (pre != 8'h00) begin
            exp_q.push_back({pre, 8'd0, 8'd0});
            push_polls(l_wel, err);
        end
        if (!err) begin
            exp_q.push_back({mop, tx, rx});
            if (wd) push_polls(l_wip, err);
        end
        has_pre = (pre != 8'h00);
        nonstat_idx = 0;
        wel_lag = l_wel;
        wip_lag = l_wip;
        @(negedge clk);
        pre_op = pre; main_op = mop; main_tx_cnt = tx; main_rx_cnt = rx;
        wait_done = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(seq_busy && !seq_done && !seq_error, {tag, " R11 start accepted and result cleared"},
              {seq_busy, seq_done, seq_error}, 3'b100);
        if (inject) begin
            repeat (3) @(negedge clk);
            pre_op = 8'h50; main_op = 8'h60; main_tx_cnt = 8'd7; main_rx_cnt = 8'd7;
            wait_done = ~wd; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (seq_busy) @(negedge clk);
        check(exp_q.size() == 0, {tag, " transactions left unlaunched"}, exp_q.size(), 0);
        exp_q.delete();
        check(seq_done == !err && seq_error == err, {tag, " result flags"},
              {seq_done, seq_error}, {!err, err});
        repeat (4) @(negedge clk);
        check(seq_done == !err && seq_error == err && !seq_busy, {tag, " R11 result held"},
              {seq_busy, seq_done, seq_error}, {1'b0, !err, err});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!seq_busy && !seq_done && !seq_error && !eng_launch, "R1 during reset",
              {seq_busy, seq_done, seq_error, eng_launch}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!seq_busy && !seq_done && !seq_error && !eng_launch, "R1 after reset",
              {seq_busy, seq_done, seq_error, eng_launch}, 0);

        run_seq(8'h06, 8'h02, 8'd4, 8'd0, 1'b1, 2, 3, 1'b0, "R2 R4 R5 R6 R7");
        run_seq(8'h00, 8'h0B, 8'd3, 8'd5, 1'b0, 0, 0, 1'b0, "R3 R8");
        run_seq(8'h06, 8'hD8, 8'd3, 8'd0, 1'b0, 0, 0, 1'b0, "R5 R8 first read passes");
        run_seq(8'h00, 8'h20, 8'd3, 8'd0, 1'b1, 0, 0, 1'b0, "R3 R7 first read passes");
        run_seq(8'h06, 8'h02, 8'd9, 8'd0, 1'b0, MAXP - 1, 0, 1'b0, "R9 WEL last read passes");
        run_seq(8'h06, 8'h02, 8'd9, 8'd0, 1'b1, MAXP, 0, 1'b0, "R9 WEL exhausted");
        run_seq(8'h00, 8'hC7, 8'd0, 8'd0, 1'b1, 0, MAXP, 1'b0, "R9 WIP exhausted");
        run_seq(8'h00, 8'hC7, 8'd0, 8'd0, 1'b1, 0, MAXP - 1, 1'b0, "R9 R11 WIP last read passes");
        run_seq(8'h06, 8'h02, 8'd2, 8'd1, 1'b1, 3, 2, 1'b1, "R10 R6 mid-sequence start ignored");
        run_seq(8'h06, 8'hAB, 8'd1, 8'd2, 1'b0, 1, 0, 1'b0, "R12 R6 after ignored start");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R12 watchdog: got hung run exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule